// File: doc/BRIEF.md
# Two-Bank Cascaded Interrupt Controller

This block collects sixteen level-sensitive interrupt sources in two banks of eight and forwards a single cascade interrupt to an upstream controller. A host reaches it through a byte-wide register port with separate read and write strobes and an 8-bit address. Each bank has a mask register, where a 1 disables a source, and a status register that shows the raw input levels inverted, so a pending source reads as 0.

Alongside the cascade line the block outputs the 4-bit number of the most urgent enabled source and a valid flag. Sources 0 to 7 sit in bank 0, bit n of bank b being source 8·b + n. Bank 0 always outranks bank 1, and within a bank the lowest bit wins. Two fixed positions of bank 1 (bits 1 and 4, sources 9 and 12) never take part. Inputs are levels, so a host clears an interrupt by masking the source or by removing its cause. A route byte and a control byte are plain read/write storage. Setup normally writes 0xFD to the route byte.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset both mask registers read 0xFF, the route and control registers read 0x00, and cascade_irq, top_valid and top_id are all 0.
- R2: Register offsets are 0 bank-0 mask, 1 bank-0 status, 2 route, 3 bank-1 mask, 4 bank-1 status, 5 bank-1 control. A value written to a mask, the route or the control register reads back unchanged.
- R3: A status register reads the bitwise inverse of the bank's source levels whatever the mask holds, and writes to offsets 1 and 4 change nothing.
- R4: A source with its mask bit at 1 never raises cascade_irq or top_valid. Clearing the bit to 0 lets a high level on that source be reported.
- R5: Sources 9 and 12 (bank-1 bits 1 and 4, pattern 0x12) are never reported and never raise cascade_irq, whatever the bank-1 mask holds.
- R6: When any enabled source of bank 0 is pending, top_id names a bank-0 source even if bank-1 sources are also pending.
- R7: Within a bank the lowest-numbered enabled pending source is reported.
- R8: cascade_irq, top_valid and top_id are registered. They reflect the levels and masks sampled at the previous rising edge, and cascade_irq and top_valid are high exactly when an enabled, non-excluded source is high.
- R9: Reads of offsets 6 to 255 return 0x00, writes there change nothing, rdata is 0x00 while rd_en is low, and top_id is 0 while top_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| src_lvl | input | 16 | Interrupt source levels, 1 = pending |
| wr_en | input | 1 | Write strobe for one cycle |
| rd_en | input | 1 | Read enable, gates rdata |
| addr | input | 8 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from addr |
| cascade_irq | output | 1 | Upstream interrupt, high while any enabled source is pending |
| top_valid | output | 1 | top_id holds a pending source |
| top_id | output | 4 | Number of the highest-priority pending source |

## Verification
A corrupted mask bit shows at the ports one clock later: cascade_irq stays silent for an enabled source or fires for a disabled one, and the same mask reads back wrong at once. A fault in the priority chain shows as a wrong top_id on the first cycle after two sources are pending together, for instance a bank-1 number while a bank-0 source is live, or a higher bit winning. A lost exclusion on bits 9 or 12 raises cascade_irq one cycle after that source alone goes high. The bench compares all three registered outputs with its own model on every clock, so any such fault is caught within one cycle of the stimulus that exposes it.

// File: rtl/irq_cascade_pkg.sv
package irq_cascade_pkg;

    localparam int BANK_W    = 8;
    localparam int NUM_BANKS = 2;
    localparam int NUM_SRC   = BANK_W * NUM_BANKS;
    localparam int ID_W      = $clog2(NUM_SRC);
    localparam int IDX_W     = $clog2(BANK_W);
    localparam int ADDR_W    = 8;

    typedef enum logic [2:0] {
        OFF_MASK0 = 3'd0,
        OFF_STAT0 = 3'd1,
        OFF_ROUTE = 3'd2,
        OFF_MASK1 = 3'd3,
        OFF_STAT1 = 3'd4,
        OFF_CTRL  = 3'd5
    } reg_off_e;

    localparam logic [BANK_W-1:0] MASK_RST   = '1;
    localparam logic [BANK_W-1:0] BANK1_EXCL = 8'h12;

    typedef struct packed {
        logic            hit;
        logic [ID_W-1:0] id;
    } prio_t;

    function automatic logic [BANK_W-1:0] excl_for_bank(input int b);
        return (b == 1) ? BANK1_EXCL : '0;
    endfunction

endpackage

// File: rtl/irq_regfile.sv
module irq_regfile
    import irq_cascade_pkg::*;
#(
    parameter int W  = BANK_W,
    parameter int AW = ADDR_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [AW-1:0]   addr,
    input  logic [W-1:0]    wdata,
    input  logic [2*W-1:0]  src_lvl,
    output logic [W-1:0]    mask0,
    output logic [W-1:0]    mask1,
    output logic [W-1:0]    rdata
);
    localparam logic [AW-1:0] A_MASK0 = AW'(OFF_MASK0);
    localparam logic [AW-1:0] A_STAT0 = AW'(OFF_STAT0);
    localparam logic [AW-1:0] A_ROUTE = AW'(OFF_ROUTE);
    localparam logic [AW-1:0] A_MASK1 = AW'(OFF_MASK1);
    localparam logic [AW-1:0] A_STAT1 = AW'(OFF_STAT1);
    localparam logic [AW-1:0] A_CTRL  = AW'(OFF_CTRL);

    logic [W-1:0] route_q, ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            mask0   <= W'(MASK_RST);
            mask1   <= W'(MASK_RST);
            route_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            if (addr == A_MASK0) mask0   <= wdata;
            if (addr == A_MASK1) mask1   <= wdata;
            if (addr == A_ROUTE) route_q <= wdata;
            if (addr == A_CTRL)  ctrl_q  <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == A_MASK0) rdata = mask0;
            if (addr == A_STAT0) rdata = ~src_lvl[W-1:0];
            if (addr == A_ROUTE) rdata = route_q;
            if (addr == A_MASK1) rdata = mask1;
            if (addr == A_STAT1) rdata = ~src_lvl[2*W-1:W];
            if (addr == A_CTRL)  rdata = ctrl_q;
        end
    end

endmodule

// File: rtl/irq_bank_prio.sv
module irq_bank_prio
    import irq_cascade_pkg::*;
#(
    parameter int           W    = BANK_W,
    parameter logic [W-1:0] EXCL = '0,
    localparam int          IW   = $clog2(W)
) (
    input  logic [W-1:0]  lvl,
    input  logic [W-1:0]  mask,
    output logic          hit,
    output logic [IW-1:0] idx
);
    logic [W-1:0] live;

    assign live = lvl & ~mask & ~EXCL;
    assign hit  = |live;

    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (live[i]) idx = IW'(i);
        end
    end

endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_lvl,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [BANK_W-1:0]  wdata,
    output logic [BANK_W-1:0]  rdata,
    output logic               cascade_irq,
    output logic               top_valid,
    output logic [ID_W-1:0]    top_id
);
    logic [BANK_W-1:0] mask_b0, mask_b1;
    logic [BANK_W-1:0] bank_mask [NUM_BANKS];
    logic              bank_hit  [NUM_BANKS];
    logic [IDX_W-1:0]  bank_idx  [NUM_BANKS];
    prio_t             nxt, cur;

    irq_regfile #(.W(BANK_W), .AW(ADDR_W)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .src_lvl(src_lvl),
        .mask0  (mask_b0),
        .mask1  (mask_b1),
        .rdata  (rdata)
    );

    assign bank_mask[0] = mask_b0;
    assign bank_mask[1] = mask_b1;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        irq_bank_prio #(.W(BANK_W), .EXCL(excl_for_bank(g))) u_prio (
            .lvl (src_lvl[g*BANK_W +: BANK_W]),
            .mask(bank_mask[g]),
            .hit (bank_hit[g]),
            .idx (bank_idx[g])
        );
    end

    // Lower bank numbers are visited last so they override higher ones.
    always_comb begin
        nxt = '0;
        for (int b = NUM_BANKS - 1; b >= 0; b--) begin
            if (bank_hit[b]) begin
                nxt.hit = 1'b1;
                nxt.id  = ID_W'(b * BANK_W) + ID_W'(bank_idx[b]);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign cascade_irq = cur.hit;
    assign top_valid   = cur.hit;
    assign top_id      = cur.id;

endmodule

// File: rtl/irq_cascade_chk.sv
module irq_cascade_chk
    import irq_cascade_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_lvl,
    input logic [BANK_W-1:0]  mask0,
    input logic [BANK_W-1:0]  mask1,
    input logic               cascade_irq,
    input logic               top_valid,
    input logic [ID_W-1:0]    top_id
);
    logic any_live;
    assign any_live = (|(src_lvl[BANK_W-1:0] & ~mask0)) ||
                      (|(src_lvl[NUM_SRC-1:BANK_W] & ~mask1 & ~BANK1_EXCL));

    assert_reset_state_R1: assert property (@(posedge clk)
        rst |=> (mask0 == MASK_RST && mask1 == MASK_RST && !cascade_irq && !top_valid));

    assert_excluded_R5: assert property (@(posedge clk) disable iff (rst)
        top_valid |-> (top_id != ID_W'(9) && top_id != ID_W'(12)));

    assert_bank0_first_R6: assert property (@(posedge clk) disable iff (rst)
        (top_valid && top_id[ID_W-1]) |-> ($past(src_lvl[BANK_W-1:0] & ~mask0) == '0));

    assert_raise_R8: assert property (@(posedge clk) disable iff (rst)
        any_live |=> cascade_irq);

    assert_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !any_live |=> !cascade_irq);

    assert_idle_id_R9: assert property (@(posedge clk) disable iff (rst)
        !top_valid |-> top_id == '0);

endmodule

bind irq_cascade_ctrl irq_cascade_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .src_lvl    (src_lvl),
    .mask0      (mask_b0),
    .mask1      (mask_b1),
    .cascade_irq(cascade_irq),
    .top_valid  (top_valid),
    .top_id     (top_id)
);

// File: tb/irq_cascade_ctrl_tb.sv
module irq_cascade_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] src_lvl = '0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;
    logic        cascade_irq, top_valid;
    logic [3:0]  top_id;

    int checks = 0;
    int errors = 0;
    bit run_model = 1'b0;

    always #4 clk = ~clk;

    irq_cascade_ctrl u_dut (
        .clk(clk), .rst(rst), .src_lvl(src_lvl), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .cascade_irq(cascade_irq),
        .top_valid(top_valid), .top_id(top_id)
    );

    // Behavioural reference: state and expected registered outputs
    logic [7:0] m_mask0, m_mask1;
    logic       e_valid;
    logic [3:0] e_id;

    always @(posedge clk) begin
        if (rst) begin
            m_mask0 <= 8'hFF;
            m_mask1 <= 8'hFF;
            e_valid <= 1'b0;
            e_id    <= 4'd0;
        end else begin
            automatic int  best = -1;
            for (int s = 15; s >= 0; s--) begin
                automatic bit masked = (s < 8) ? m_mask0[s] : m_mask1[s-8];
                if (src_lvl[s] && !masked && s != 9 && s != 12) best = s;
            end
            e_valid <= (best >= 0);
            e_id    <= (best >= 0) ? 4'(best) : 4'd0;
            if (wr_en && addr == 8'd0) m_mask0 <= wdata;
            if (wr_en && addr == 8'd3) m_mask1 <= wdata;
        end
    end

    always @(negedge clk) begin
        if (run_model) begin
            checks++;
            if (cascade_irq !== e_valid || top_valid !== e_valid || top_id !== e_id) begin
                errors++;
                $display("FAIL R8 per-cycle: casc=%b valid=%b id=%0d expected casc=%b valid=%b id=%0d",
                         cascade_irq, top_valid, top_id, e_valid, e_valid, e_id);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic en,
                          input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        rd_en = en; addr = a;
        @(negedge clk);
        checks++;
        if (rdata !== exp) begin
            errors++;
            $display("FAIL %s read addr %0d: got %h expected %h", tag, a, rdata, exp);
        end
        rd_en = 1'b0;
    endtask

    task automatic set_src(input logic [15:0] v);
        @(posedge clk); #1;
        src_lvl = v;
        @(posedge clk); @(posedge clk);
    endtask

    task automatic chk_out(input logic v, input logic [3:0] id, input string tag);
        @(negedge clk);
        checks++;
        if (cascade_irq !== v || top_valid !== v || top_id !== id) begin
            errors++;
            $display("FAIL %s: casc=%b valid=%b id=%0d expected valid=%b id=%0d",
                     tag, cascade_irq, top_valid, top_id, v, id);
        end
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        run_model = 1'b1;
        // R1 reset state
        chk_out(1'b0, 4'd0, "R1 outputs");
        chk_rd(8'd0, 1'b1, 8'hFF, "R1 mask0");
        chk_rd(8'd3, 1'b1, 8'hFF, "R1 mask1");
        chk_rd(8'd2, 1'b1, 8'h00, "R1 route");
        chk_rd(8'd5, 1'b1, 8'h00, "R1 ctrl");
        // R2 register map readback
        wr(8'd2, 8'hFD);
        wr(8'd5, 8'h5A);
        chk_rd(8'd2, 1'b1, 8'hFD, "R2 route");
        chk_rd(8'd5, 1'b1, 8'h5A, "R2 ctrl");
        chk_rd(8'd0, 1'b1, 8'hFF, "R2 mask0 untouched");
        // R3 status inverted regardless of mask, writes ignored
        set_src(16'h2001);
        chk_rd(8'd1, 1'b1, 8'hFE, "R3 status0");
        chk_rd(8'd4, 1'b1, 8'hDF, "R3 status1");
        wr(8'd1, 8'h00);
        wr(8'd4, 8'h00);
        chk_rd(8'd1, 1'b1, 8'hFE, "R3 status0 after write");
        chk_rd(8'd0, 1'b1, 8'hFF, "R3 mask0 after status write");
        chk_rd(8'd3, 1'b1, 8'hFF, "R3 mask1 after status write");
        // R4 masked source silent, unmasked reported
        chk_out(1'b0, 4'd0, "R4 all masked");
        wr(8'd0, 8'h00);
        chk_rd(8'd0, 1'b1, 8'h00, "R2 mask0 readback");
        chk_out(1'b1, 4'd0, "R4 unmask src0");
        // R7 lowest bit wins in bank 0
        set_src(16'h00A0);
        chk_out(1'b1, 4'd5, "R7 bank0 lowest");
        // R4 ack by masking
        set_src(16'h0003);
        wr(8'd0, 8'h01);
        @(posedge clk);
        chk_out(1'b1, 4'd1, "R4 masked src0 acked");
        // R5 excluded bits with bank-1 fully enabled
        wr(8'd0, 8'hFF);
        wr(8'd3, 8'h00);
        set_src(16'h1200);
        chk_out(1'b0, 4'd0, "R5 excluded only");
        set_src(16'h1600);
        chk_out(1'b1, 4'd10, "R5 R7 bank1 next after excluded");
        // R6 bank 0 beats bank 1
        wr(8'd0, 8'h00);
        set_src(16'h8180);
        chk_out(1'b1, 4'd7, "R6 bank0 over bank1");
        set_src(16'h8100);
        chk_out(1'b1, 4'd8, "R6 bank1 when bank0 idle");
        // R9 unused addresses and rd_en low
        wr(8'd6, 8'h33);
        wr(8'd255, 8'h44);
        chk_rd(8'd6, 1'b1, 8'h00, "R9 addr 6");
        chk_rd(8'd255, 1'b1, 8'h00, "R9 addr 255");
        chk_rd(8'd2, 1'b0, 8'h00, "R9 rd_en low");
        chk_rd(8'd2, 1'b1, 8'hFD, "R9 route unchanged");
        set_src(16'h0000);
        chk_out(1'b0, 4'd0, "R9 idle id zero");
        @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule